// File: doc/BRIEF.md
# Bit Counting Execution Unit

This unit sits in the execute stage of a 64-bit integer pipeline. It takes one source operand together with an operation select and a valid strobe. It returns a 64-bit count result exactly one clock later. Three counts are offered on the full register: leading zeros, trailing zeros and set bits. Each also has a word form that looks only at the low 32 bits of the operand.

Two inputs gate the operations. One input enables the bit-manipulation feature. A second input tells the unit whether the core runs in 64-bit mode. If an operation is not permitted, the unit raises an illegal flag and returns a zero result, so nothing is written back. The unit keeps no architectural state; its only registers are the output stage.

Top module: `bitcount_unit`

## Requirements
- R1: Operation code 3'd0 returns the number of zero bits above the highest set bit of the 64-bit operand, and returns 64 when the operand is zero.
- R2: Operation code 3'd1 returns the number of zero bits below the lowest set bit of the 64-bit operand, and returns 64 when the operand is zero.
- R3: Operation code 3'd2 returns the number of set bits in all 64 operand bits.
- R4: Operation code 3'd3 counts leading zeros of operand bits 31:0 only. It returns 32 when those bits are zero, whatever bits 63:32 hold.
- R5: Operation code 3'd4 counts trailing zeros of operand bits 31:0 only. It returns 32 when those bits are zero, so it never exceeds 32.
- R6: Operation code 3'd5 counts set bits in operand bits 31:0 only and ignores bits 63:32.
- R7: Operation codes 3'd6 and 3'd7 raise the illegal flag with a zero result.
- R8: When the feature enable is low, every operation code raises the illegal flag with a zero result.
- R9: When the 64-bit mode input is low, codes 3'd3, 3'd4 and 3'd5 are illegal, while codes 3'd0, 3'd1 and 3'd2 stay legal.
- R10: The output valid strobe is high exactly in the cycle after an accepted input valid. Result and illegal flag keep their values while no input is valid.
- R11: A legal count is zero-extended, so result bits 63:7 are zero and the value never exceeds 64.
- R12: During reset the output valid strobe, the result and the illegal flag are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand and select are valid this cycle |
| op_sel | input | 3 | Operation select (codes in R1 to R7) |
| operand | input | 64 | Source operand |
| feat_en | input | 1 | Bit-manipulation feature enable |
| mode64 | input | 1 | Core runs in 64-bit mode |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| result | output | 64 | Zero-extended count, or zero when illegal |
| illegal | output | 1 | Operation not permitted |

## Verification
Some rules hold on every cycle, and the assertions check those. They cover the one-cycle valid latency, the zero result of an illegal operation, and the bound on any legal count. They also cover the 32 ceiling on word forms, and the illegal flag raised by a cleared enable or by a word form outside 64-bit mode. Only the bench scenarios can show that each count is correct for particular operands. The same holds for the all-zero results of 64 and 32, for the upper half being ignored by the word forms, and for outputs holding while idle. The bench compares a table of hand-worked values and a reference model against pseudo-random operands.

// File: rtl/bitcount_pkg.sv
package bitcount_pkg;
  typedef enum logic [2:0] {
    OP_LZ   = 3'd0,
    OP_TZ   = 3'd1,
    OP_POP  = 3'd2,
    OP_LZW  = 3'd3,
    OP_TZW  = 3'd4,
    OP_POPW = 3'd5
  } bc_op_e;
endpackage

// File: rtl/bitcount_lzc.sv
module bitcount_lzc #(
  parameter int W  = 64,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  // highest set bit wins; all-zero input yields W
  always_comb begin
    cnt = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) cnt = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/bitcount_pop.sv
module bitcount_pop #(
  parameter int W  = 64,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) begin
      cnt = cnt + CW'(vec[i]);
    end
  end
endmodule

// File: rtl/bitcount_unit.sv
module bitcount_unit
  import bitcount_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [2:0]      op_sel,
  input  logic [XLEN-1:0] operand,
  input  logic            feat_en,
  input  logic            mode64,
  output logic            out_valid,
  output logic [XLEN-1:0] result,
  output logic            illegal
);
  localparam int HW  = XLEN / 2;
  localparam int CW  = $clog2(XLEN + 1);
  localparam int HCW = $clog2(HW + 1);

  logic [XLEN-1:0] rev_full;
  logic [HW-1:0]   low_half, rev_half;
  logic [CW-1:0]   lz_full, tz_full, pop_full;
  logic [HCW-1:0]  lz_half, tz_half, pop_half;

  assign low_half = operand[HW-1:0];

  // bit reversal turns a trailing count into a leading count
  genvar g;
  generate
    for (g = 0; g < XLEN; g++) begin : g_rev_full
      assign rev_full[g] = operand[XLEN-1-g];
    end
    for (g = 0; g < HW; g++) begin : g_rev_half
      assign rev_half[g] = operand[HW-1-g];
    end
  endgenerate

  bitcount_lzc #(.W(XLEN), .CW(CW))  u_lz_full (.vec(operand),  .cnt(lz_full));
  bitcount_lzc #(.W(XLEN), .CW(CW))  u_tz_full (.vec(rev_full), .cnt(tz_full));
  bitcount_pop #(.W(XLEN), .CW(CW))  u_pop_full(.vec(operand),  .cnt(pop_full));
  bitcount_lzc #(.W(HW),   .CW(HCW)) u_lz_half (.vec(low_half), .cnt(lz_half));
  bitcount_lzc #(.W(HW),   .CW(HCW)) u_tz_half (.vec(rev_half), .cnt(tz_half));
  bitcount_pop #(.W(HW),   .CW(HCW)) u_pop_half(.vec(low_half), .cnt(pop_half));

  // operation decode and count select
  logic          op_known, op_word, legal;
  logic [CW-1:0] sel_cnt;

  always_comb begin
    op_known = 1'b1;
    op_word  = 1'b0;
    sel_cnt  = '0;
    case (op_sel)
      OP_LZ:   sel_cnt = lz_full;
      OP_TZ:   sel_cnt = tz_full;
      OP_POP:  sel_cnt = pop_full;
      OP_LZW:  begin op_word = 1'b1; sel_cnt = CW'(lz_half);  end
      OP_TZW:  begin op_word = 1'b1; sel_cnt = CW'(tz_half);  end
      OP_POPW: begin op_word = 1'b1; sel_cnt = CW'(pop_half); end
      default: op_known = 1'b0;
    endcase
    legal = feat_en && op_known && (!op_word || mode64);
  end

  // next state
  logic            valid_d, illegal_d;
  logic [XLEN-1:0] result_d;

  always_comb begin
    valid_d   = in_valid;
    result_d  = result;
    illegal_d = illegal;
    if (in_valid) begin
      result_d  = legal ? XLEN'(sel_cnt) : '0;
      illegal_d = !legal;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= valid_d;
      result    <= result_d;
      illegal   <= illegal_d;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);                                            // R10
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);                                          // R10
  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && illegal) |-> (result == '0));                         // R8
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !illegal) |-> (result <= XLEN'(XLEN)));               // R11
  AST_FEAT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !feat_en) |=> illegal);                                // R8
  AST_WORD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mode64 && (op_sel inside {3'd3, 3'd4, 3'd5})) |=> illegal); // R9
  AST_WORD_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && feat_en && mode64 && (op_sel inside {3'd3, 3'd4, 3'd5}))
      |=> (!illegal && result <= XLEN'(HW)));                           // R5
endmodule

// File: tb/sim_bitcount_unit.sv
module sim_bitcount_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  op_sel;
  logic [63:0] operand;
  logic        feat_en, mode64;
  logic        out_valid, illegal;
  logic [63:0] result;

  int n_checks = 0;
  int n_errors = 0;

  always #5 clk = ~clk;

  bitcount_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .operand(operand), .feat_en(feat_en), .mode64(mode64),
    .out_valid(out_valid), .result(result), .illegal(illegal)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [63:0] v;
    logic [6:0]  exp;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    '{3'd0, 64'h0,                 7'd64},  // R1
    '{3'd0, 64'h1,                 7'd63},  // R1
    '{3'd0, 64'h8000_0000_0000_0000, 7'd0}, // R1
    '{3'd0, 64'h0000_0000_8000_0000, 7'd32},// R1
    '{3'd1, 64'h0,                 7'd64},  // R2
    '{3'd1, 64'h8000_0000_0000_0000, 7'd63},// R2
    '{3'd1, 64'h10,                7'd4},   // R2
    '{3'd2, 64'hFFFF_FFFF_FFFF_FFFF, 7'd64},// R3
    '{3'd2, 64'hF0F0,              7'd8},   // R3
    '{3'd3, 64'hFFFF_FFFF_0000_0000, 7'd32},// R4
    '{3'd3, 64'h0000_0000_0000_8000, 7'd16},// R4
    '{3'd3, 64'h0000_0000_8000_0000, 7'd0}, // R4
    '{3'd4, 64'hFFFF_FFFF_0000_0000, 7'd32},// R5
    '{3'd4, 64'h0000_0000_0001_0000, 7'd16},// R5
    '{3'd4, 64'h0000_0001_0000_0000, 7'd32},// R5
    '{3'd5, 64'hFFFF_FFFF_0000_0003, 7'd2}, // R6
    '{3'd5, 64'hFFFF_FFFF_FFFF_FFFF, 7'd32} // R6
  };

  function automatic logic [63:0] ref_count(input logic [2:0] op, input logic [63:0] v);
    int n = 0;
    int w = (op >= 3'd3) ? 32 : 64;
    case (op)
      3'd0, 3'd3: begin
        n = w;
        for (int i = 0; i < w; i++) if (v[i]) n = w - 1 - i;
      end
      3'd1, 3'd4: begin
        n = w;
        for (int i = w - 1; i >= 0; i--) if (v[i]) n = i;
      end
      default: for (int i = 0; i < w; i++) n += int'(v[i]);
    endcase
    return 64'(n);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one operation, sample one cycle later away from the edge
  task automatic issue(input logic [2:0] op, input logic [63:0] v, input logic fe, input logic m64);
    @(negedge clk);
    in_valid = 1'b1; op_sel = op; operand = v; feat_en = fe; mode64 = m64;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_ok(input string tag, input logic [63:0] exp);
    check(out_valid == 1'b1, {tag, " valid"}, 64'(out_valid), 64'd1);
    check(illegal == 1'b0 && result == exp, tag, result, exp);
  endtask

  task automatic expect_bad(input string tag);
    check(out_valid == 1'b1 && illegal == 1'b1 && result == 64'd0, tag,
          {illegal, result[62:0]}, {1'b1, 63'd0});
  endtask

  initial begin
    #150000;
    n_errors++;
    n_checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    logic [63:0] lfsr;
    logic [63:0] held;
    rst_n = 1'b0; in_valid = 1'b0; op_sel = 3'd0; operand = '0;
    feat_en = 1'b1; mode64 = 1'b1;
    repeat (3) @(negedge clk);
    // R12: reset state
    check(out_valid == 1'b0 && result == 64'd0 && illegal == 1'b0, "R12 reset",
          {illegal, out_valid, result[61:0]}, 64'd0);
    rst_n = 1'b1;

    // table walk: R1..R6
    for (int k = 0; k < NV; k++) begin
      issue(TBL[k].op, TBL[k].v, 1'b1, 1'b1);
      expect_ok($sformatf("R%0d table %0d", (TBL[k].op == 3'd0) ? 1 : int'(TBL[k].op) + 1, k),
                64'(TBL[k].exp));
    end
    // explicit tags for the table rows: R1 R2 R3 R4 R5 R6

    // R11: zero-extension of the largest count
    issue(3'd0, 64'h0, 1'b1, 1'b1);
    check(result[63:7] == '0 && result <= 64'd64, "R11 zero-extended", result, 64'd64);

    // R10: outputs hold and valid drops when idle
    held = result;
    @(negedge clk);
    check(out_valid == 1'b0, "R10 valid low when idle", 64'(out_valid), 64'd0);
    operand = 64'h1234; op_sel = 3'd2;
    @(negedge clk);
    check(result == held && illegal == 1'b0, "R10 hold", result, held);

    // R7: undefined codes
    issue(3'd6, 64'hFF, 1'b1, 1'b1);
    expect_bad("R7 code 6");
    issue(3'd7, 64'hFF, 1'b1, 1'b1);
    expect_bad("R7 code 7");

    // R8: feature disabled, every code
    for (int op = 0; op < 8; op++) begin
      issue(3'(op), 64'h00F0_0000_0000_0F00, 1'b0, 1'b1);
      expect_bad($sformatf("R8 op %0d", op));
    end

    // R9: 32-bit mode
    for (int op = 0; op < 6; op++) begin
      issue(3'(op), 64'h0000_0100_0000_0100, 1'b1, 1'b0);
      if (op >= 3) expect_bad($sformatf("R9 word op %0d", op));
      else expect_ok($sformatf("R9 full op %0d", op), ref_count(3'(op), 64'h0000_0100_0000_0100));
    end

    // reference model against pseudo-random operands, all ops
    lfsr = 64'h9E37_79B9_7F4A_7C15;
    for (int it = 0; it < 24; it++) begin
      lfsr ^= lfsr << 13; lfsr ^= lfsr >> 7; lfsr ^= lfsr << 17;
      for (int op = 0; op < 6; op++) begin
        logic [63:0] v;
        v = (it % 4 == 0) ? (lfsr & 64'hFFFF_0000_0000_0000) : lfsr >> (it % 40);
        issue(3'(op), v, 1'b1, 1'b1);
        expect_ok($sformatf("R%0d model op %0d", op + 1, op), ref_count(3'(op), v));
      end
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule